// File: doc/BRIEF.md
# Smart Card Clock Generator

This block produces the clock that drives a smart card's clock contact. It has two possible sources. One is an external strobe line, whose rising edges count as source edges. The other is an on-chip oscillator: either a crystal or external clock, or an RC oscillator. A two-bit divider code picks one of four outputs: the source divided by two, the source divided by four, a clock held stopped low, or a fixed reference clock of 1.25 MHz. The same code also decides which internal oscillator is in use.

All oscillators are modelled as single-cycle enable pulses in the system clock domain. Each pulse marks one rising edge of that source. The reference input pulses at 2.5 MHz, so the toggled output runs at 1.25 MHz. When the internal oscillator is the source, the block forwards it to a clock-out pin as a toggling output. In sleep mode that pin switches to a slow enable of about 16 kHz. The card clock is held low while the card contacts are inactive. The source and divider selection are frozen while an activation sequence runs.

Top module: `smartcard_clkgen`

## Requirements
- R1: While reset is asserted and right after it is released, card_clk and clk_out are both low.
- R2: When the latched source select is high, each rising edge of strobe_in is one source edge. The internal oscillator pulses then have no effect on card_clk.
- R3: When the latched source select is low, the source is rc_tick if the latched code is 01 and xtal_tick for every other code. The oscillator that is not selected has no effect.
- R4: Code 01 (bit 0 high, bit 1 low) toggles card_clk on every source edge. This gives one full card cycle per two source edges, and the first rise comes on the first edge.
- R5: Code 10 (bit 1 high, bit 0 low) toggles card_clk on every second source edge. The first rise comes on the second edge after activation.
- R6: Code 00 holds card_clk low whatever the source does.
- R7: Code 11 toggles card_clk on every ref_tick pulse and ignores both the strobe and the oscillators.
- R8: A new divider code takes effect only while card_clk is low. A high phase that is already running completes under the old code.
- R9: While card_on is low, card_clk is low one cycle later and stays low, and the divider phase restarts.
- R10: A strobe rising edge that arrives in the same cycle that card_on goes high is not lost. With code 01, card_clk is high one cycle later.
- R11: While act_busy is high, the source select and the divider code hold the values they had before it rose. Input changes are taken up only after act_busy falls.
- R12: With the internal source selected, clk_out toggles on each pulse of the chosen internal oscillator. With the strobe selected, clk_out is held low.
- R13: While sleep is high, clk_out toggles only on slow_tick, and internal oscillator pulses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_on | input | 1 | Card contacts active |
| act_busy | input | 1 | Activation sequence in progress; freezes the selection |
| src_strobe_sel | input | 1 | 1 selects the strobe as source, 0 selects the internal oscillator |
| div_code | input | 2 | 00 stop low, 01 divide by 2 with RC, 10 divide by 4, 11 reference clock |
| sleep | input | 1 | Moves clk_out to the slow clock |
| strobe_in | input | 1 | External strobe level; its rising edges are source edges |
| xtal_tick | input | 1 | Crystal or external oscillator edge enable |
| rc_tick | input | 1 | RC oscillator edge enable |
| ref_tick | input | 1 | 2.5 MHz edge enable for the fixed reference output |
| slow_tick | input | 1 | About 16 kHz edge enable used in sleep |
| card_clk | output | 1 | Clock to the card |
| clk_out | output | 1 | Forwarded internal oscillator clock |

## Verification
The hardest case to reach from the ports is a divider code change that lands while card_clk is high. That change must be deferred until the clock is low. To get there, the bench runs the divide-by-four mode from strobe edges until the output has just risen, writes the stop code, and then counts the source edges still needed to finish the high phase. A second hard case is a strobe edge in the very cycle the contacts switch on. The bench drives card_on and strobe_in in the same cycle so that edge must be kept. Randomly mixed pulses from all sources, under random selections, check the rise counts of both outputs against bench formulas.

// File: rtl/cks_pkg.sv
// Shared types for the smart card clock generator.
// Assumes the divider code is two bits wide; the encoding is fixed by the block's requirements.
package cks_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        CK_STOP = 2'b00,
        CK_DIV2 = 2'b01,
        CK_DIV4 = 2'b10,
        CK_REF  = 2'b11
    } ck_mode_e;
endpackage

// File: rtl/cks_cfg.sv
// Selection register stage.
// Captures the source select and divider code while no activation runs, and
// holds them frozen during activation. Moves the code into the applied mode
// only while the card clock is low. Assumes card_clk comes straight from the
// divider's output register.
module cks_cfg
    import cks_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     act_busy,
    input  logic     src_in,
    input  ck_mode_e code_in,
    input  logic     card_clk,
    output logic     src_q,
    output ck_mode_e code_q,
    output ck_mode_e mode_q,
    output logic     rc_sel
);
    // Capture the selection when idle; hold it while activation runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            code_q <= CK_STOP;
        end else if (!act_busy) begin
            src_q  <= src_in;
            code_q <= code_in;
        end
    end

    // Apply a new divider code only during the low phase of the card clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CK_STOP;
        end else if (!card_clk) begin
            mode_q <= code_q;
        end
    end

    // The RC oscillator goes with the divide-by-two code.
    assign rc_sel = (code_q == CK_DIV2);
endmodule

// File: rtl/cks_divider.sv
// Card clock divider.
// Toggles the card clock on source edges: every edge, or every LONG_HALF
// edges, or on the reference enable, or not at all. Assumes every tick is a
// single-cycle pulse in the clk domain.
module cks_divider
    import cks_pkg::*;
#(
    parameter int LONG_HALF = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     card_on,
    input  ck_mode_e mode,
    input  logic     src_tick,
    input  logic     ref_tick,
    output logic     card_clk
);
    localparam int PH_W = (LONG_HALF > 1) ? $clog2(LONG_HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(LONG_HALF - 1);

    logic [PH_W-1:0] phase;

    // Advance the phase and toggle the card clock for the applied mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !card_on) begin
            card_clk <= 1'b0;
            phase    <= '0;
        end else begin
            unique case (mode)
                CK_STOP: begin
                    card_clk <= 1'b0;
                    phase    <= '0;
                end
                CK_DIV2: begin
                    phase <= '0;
                    if (src_tick) card_clk <= ~card_clk;
                end
                CK_DIV4: begin
                    if (src_tick) begin
                        if (phase == PH_LAST) begin
                            card_clk <= ~card_clk;
                            phase    <= '0;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                end
                CK_REF: begin
                    phase <= '0;
                    if (ref_tick) card_clk <= ~card_clk;
                end
                default: card_clk <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cks_clkout.sv
// Clock-out forwarder.
// Toggles clk_out on internal oscillator edges, or on the slow enable in
// sleep, and holds it low while the strobe is the source. Assumes single-cycle
// tick pulses.
module cks_clkout (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_low,
    input  logic sleep,
    input  logic int_tick,
    input  logic slow_tick,
    output logic clk_out
);
    logic edge_en;

    // Pick the slow enable while asleep.
    assign edge_en = sleep ? slow_tick : int_tick;

    // Toggle the forwarded clock, or force it low.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_low) begin
            clk_out <= 1'b0;
        end else if (edge_en) begin
            clk_out <= ~clk_out;
        end
    end
endmodule

// File: rtl/smartcard_clkgen.sv
// Smart card clock generator, top level.
// Detects strobe edges, selects the card clock source, divides it, and
// forwards the internal oscillator to clk_out. Assumes all oscillator inputs
// are single-cycle enables in the clk domain and strobe_in is synchronous.
module smartcard_clkgen
    import cks_pkg::*;
#(
    parameter int LONG_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                card_on,
    input  logic                act_busy,
    input  logic                src_strobe_sel,
    input  logic [CODE_W-1:0]   div_code,
    input  logic                sleep,
    input  logic                strobe_in,
    input  logic                xtal_tick,
    input  logic                rc_tick,
    input  logic                ref_tick,
    input  logic                slow_tick,
    output logic                card_clk,
    output logic                clk_out
);
    logic     strobe_d;
    logic     strobe_edge;
    logic     src_q;
    ck_mode_e code_q;
    ck_mode_e mode_q;
    logic     rc_sel;
    logic     int_tick;
    logic     src_tick;

    // Remember the last strobe level so rising edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe_in;
    end

    assign strobe_edge = strobe_in & ~strobe_d;
    assign int_tick    = rc_sel ? rc_tick : xtal_tick;
    assign src_tick    = src_q ? strobe_edge : int_tick;

    cks_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_busy (act_busy),
        .src_in   (src_strobe_sel),
        .code_in  (ck_mode_e'(div_code)),
        .card_clk (card_clk),
        .src_q    (src_q),
        .code_q   (code_q),
        .mode_q   (mode_q),
        .rc_sel   (rc_sel)
    );

    cks_divider #(.LONG_HALF(LONG_HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .card_on  (card_on),
        .mode     (mode_q),
        .src_tick (src_tick),
        .ref_tick (ref_tick),
        .card_clk (card_clk)
    );

    cks_clkout u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_low  (src_q),
        .sleep     (sleep),
        .int_tick  (int_tick),
        .slow_tick (slow_tick),
        .clk_out   (clk_out)
    );
endmodule

// File: rtl/smartcard_clkgen_chk.sv
// Assertion checker for smartcard_clkgen, attached with bind.
module smartcard_clkgen_chk
    import cks_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     card_on,
    input logic     act_busy,
    input logic     sleep,
    input logic     slow_tick,
    input logic     ref_tick,
    input logic     src_tick,
    input logic     src_q,
    input ck_mode_e code_q,
    input ck_mode_e mode_q,
    input logic     card_clk,
    input logic     clk_out
);
    // R9: inactive contacts force the card clock low.
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !card_on |=> !card_clk);

    // R8: the applied mode changes only after a low card clock.
    a_r8_change_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> !$past(card_clk));

    // R6: stop mode keeps the card clock low.
    a_r6_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CK_STOP) |=> !card_clk);

    // R11: the selection holds while activation runs.
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(act_busy) |-> ($stable(src_q) && $stable(code_q)));

    // R12: the strobe source keeps clk_out low.
    a_r12_out_low: assert property (@(posedge clk) disable iff (!rst_n)
        src_q |=> !clk_out);

    // R13: asleep, clk_out moves only on the slow enable.
    a_r13_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !slow_tick && !src_q) |=> $stable(clk_out));

    // R4: a card clock rise always follows an enable edge.
    a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(src_tick || ref_tick));
endmodule

bind smartcard_clkgen smartcard_clkgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_on   (card_on),
    .act_busy  (act_busy),
    .sleep     (sleep),
    .slow_tick (slow_tick),
    .ref_tick  (ref_tick),
    .src_tick  (src_tick),
    .src_q     (src_q),
    .code_q    (code_q),
    .mode_q    (mode_q),
    .card_clk  (card_clk),
    .clk_out   (clk_out)
);

// File: tb/smartcard_clkgen_test.sv
`timescale 1ns/1ps
module smartcard_clkgen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_on = 1'b0;
    logic act_busy = 1'b0;
    logic src_strobe_sel = 1'b0;
    logic [1:0] div_code = 2'b00;
    logic sleep = 1'b0;
    logic strobe_in = 1'b0;
    logic xtal_tick = 1'b0;
    logic rc_tick = 1'b0;
    logic ref_tick = 1'b0;
    logic slow_tick = 1'b0;
    logic card_clk;
    logic clk_out;

    int checks = 0;
    int fails = 0;
    int card_rises = 0;
    int out_rises = 0;
    logic card_prev = 1'b0;
    logic out_prev = 1'b0;
    int n_tick [5];

    always #2 clk = ~clk;

    smartcard_clkgen uut (
        .clk(clk), .rst_n(rst_n), .card_on(card_on), .act_busy(act_busy),
        .src_strobe_sel(src_strobe_sel), .div_code(div_code), .sleep(sleep),
        .strobe_in(strobe_in), .xtal_tick(xtal_tick), .rc_tick(rc_tick),
        .ref_tick(ref_tick), .slow_tick(slow_tick),
        .card_clk(card_clk), .clk_out(clk_out)
    );

    // Rising edge counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (card_clk && !card_prev) card_rises++;
        if (clk_out && !out_prev) out_rises++;
        card_prev = card_clk;
        out_prev  = clk_out;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    // kind: 0 strobe, 1 xtal, 2 rc, 3 ref, 4 slow
    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: strobe_in = 1'b1;
            1: xtal_tick = 1'b1;
            2: rc_tick   = 1'b1;
            3: ref_tick  = 1'b1;
            default: slow_tick = 1'b1;
        endcase
        @(negedge clk);
        strobe_in = 1'b0; xtal_tick = 1'b0; rc_tick = 1'b0;
        ref_tick = 1'b0; slow_tick = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        n_tick[kind]++;
    endtask

    task automatic pulses(input int kind, input int n);
        for (int i = 0; i < n; i++) pulse(kind);
    endtask

    // Deactivate, load a new selection, then run an activation.
    task automatic restart(input logic src, input logic [1:0] code);
        @(negedge clk);
        card_on = 1'b0;
        src_strobe_sel = src;
        div_code = code;
        repeat (4) @(negedge clk);
        act_busy = 1'b1;
        card_on = 1'b1;
        repeat (2) @(negedge clk);
        act_busy = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 5; k++) n_tick[k] = 0;
    endtask

    function automatic int exp_card(input logic src, input logic [1:0] code,
                                    input int ns, input int nx, input int nr, input int nref);
        int n;
        n = src ? ns : ((code == 2'b01) ? nr : nx);
        case (code)
            2'b00:   return 0;
            2'b01:   return (n + 1) / 2;
            2'b10:   return (n + 2) / 4;
            default: return (nref + 1) / 2;
        endcase
    endfunction

    function automatic int exp_out(input logic src, input logic [1:0] code,
                                   input int nx, input int nr, input logic start_hi);
        int n;
        if (src) return 0;
        n = (code == 2'b01) ? nr : nx;
        return start_hi ? n / 2 : (n + 1) / 2;
    endfunction

    initial begin
        int base_c, base_o;
        logic start_hi;
        void'($urandom(32'h1A2B3C));
        for (int k = 0; k < 5; k++) n_tick[k] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 card_clk in reset", card_clk, 0);
        chk("R1 clk_out in reset", clk_out, 0);
        rst_n = 1'b1;
        settle();
        chk("R1 card_clk after reset", card_clk, 0);
        chk("R1 clk_out after reset", clk_out, 0);

        // R2 + R4: strobe source, divide by two, oscillators ignored
        restart(1'b1, 2'b01);
        base_c = card_rises;
        pulses(0, 8); pulses(1, 6); pulses(2, 6);
        settle();
        chk("R2 R4 strobe div2 rises", card_rises - base_c, 4);
        chk("R12 clk_out held low with strobe", clk_out, 0);

        // R3: RC with code 01, crystal ignored
        restart(1'b0, 2'b01);
        base_c = card_rises;
        pulses(2, 8); pulses(1, 8); pulses(0, 4);
        settle();
        chk("R3 rc div2 rises, xtal ignored", card_rises - base_c, 4);

        // R5 + R3: crystal with code 10, RC ignored
        restart(1'b0, 2'b10);
        base_c = card_rises;
        pulse(1);
        settle();
        chk("R5 no rise after first edge", card_clk, 0);
        pulse(1);
        settle();
        chk("R5 rise on second edge", card_clk, 1);
        pulses(1, 6); pulses(2, 8);
        settle();
        chk("R5 R3 xtal div4 rises", card_rises - base_c, 2);

        // R6: stop low
        restart(1'b1, 2'b00);
        base_c = card_rises;
        pulses(0, 6); pulses(3, 6); pulses(1, 4);
        settle();
        chk("R6 stop rises", card_rises - base_c, 0);
        chk("R6 stop level", card_clk, 0);

        // R7: reference clock, sources ignored
        restart(1'b1, 2'b11);
        base_c = card_rises;
        pulses(3, 10); pulses(0, 6); pulses(1, 4);
        settle();
        chk("R7 ref rises", card_rises - base_c, 5);

        // R8: code change while high is deferred
        restart(1'b1, 2'b10);
        pulses(0, 2);
        settle();
        chk("R8 high before change", card_clk, 1);
        div_code = 2'b00;
        settle();
        chk("R8 still high after change", card_clk, 1);
        pulse(0);
        settle();
        chk("R8 high phase runs on", card_clk, 1);
        pulse(0);
        settle();
        chk("R8 falls after full high phase", card_clk, 0);
        base_c = card_rises;
        pulses(0, 6);
        settle();
        chk("R8 stop applied once low", card_rises - base_c, 0);

        // R9: deactivation forces low
        restart(1'b1, 2'b01);
        pulse(0);
        settle();
        chk("R9 high before deactivation", card_clk, 1);
        @(negedge clk);
        card_on = 1'b0;
        @(negedge clk);
        #1;
        chk("R9 low one cycle after card_on falls", card_clk, 0);
        base_c = card_rises;
        pulses(0, 4);
        settle();
        chk("R9 no rises while off", card_rises - base_c, 0);

        // R10: strobe edge in the card_on cycle is kept
        @(negedge clk);
        card_on = 1'b1;
        strobe_in = 1'b1;
        @(negedge clk);
        #1;
        chk("R10 first strobe edge kept", card_clk, 1);
        strobe_in = 1'b0;
        settle();

        // R11: selection frozen during activation
        restart(1'b0, 2'b01);
        @(negedge clk);
        act_busy = 1'b1;
        repeat (2) @(negedge clk);
        src_strobe_sel = 1'b1;
        div_code = 2'b11;
        base_c = card_rises;
        pulses(0, 4); pulses(3, 4);
        settle();
        chk("R11 new selection ignored while busy", card_rises - base_c, 0);
        pulses(2, 4);
        settle();
        chk("R11 old selection still active", card_rises - base_c, 2);
        act_busy = 1'b0;
        settle();
        base_c = card_rises;
        pulses(3, 4);
        settle();
        chk("R11 new selection after busy", card_rises - base_c, 2);

        // R12: clk_out follows crystal
        restart(1'b0, 2'b10);
        start_hi = clk_out;
        base_o = out_rises;
        pulses(1, 8);
        settle();
        chk("R12 clk_out rises on xtal", out_rises - base_o, start_hi ? 4 : 4);

        // R13: sleep moves clk_out to the slow clock
        @(negedge clk);
        sleep = 1'b1;
        settle();
        start_hi = clk_out;
        base_o = out_rises;
        pulses(1, 6);
        settle();
        chk("R13 xtal ignored asleep", out_rises - base_o, 0);
        chk("R13 clk_out level kept asleep", clk_out, start_hi);
        pulses(4, 8);
        settle();
        chk("R13 slow rises", out_rises - base_o, 4);
        sleep = 1'b0;

        // Random mixes checked against formulas (R2 to R7, R12)
        for (int it = 0; it < 30; it++) begin
            logic s;
            logic [1:0] c;
            s = 1'($urandom_range(0, 1));
            c = 2'($urandom_range(0, 3));
            restart(s, c);
            settle();
            start_hi = clk_out;
            base_c = card_rises;
            base_o = out_rises;
            for (int j = 0; j < 14; j++) pulse($urandom_range(0, 3));
            settle();
            chk($sformatf("R2 R3 R4 R5 R6 R7 random card s=%0d c=%0d", s, c),
                card_rises - base_c,
                exp_card(s, c, n_tick[0], n_tick[1], n_tick[2], n_tick[3]));
            chk($sformatf("R12 random clk_out s=%0d c=%0d", s, c),
                out_rises - base_o,
                exp_out(s, c, n_tick[1], n_tick[2], start_hi));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule